// File: doc/BRIEF.md
# Array Line Redundancy Remapper

This block sits in front of the array decoders of a multi-sector nonvolatile memory. It redirects accesses away from array lines that failed at wafer sort and onto spare lines. The array is split into vertical groups of sectors, and each group shares two kinds of spare. Column spares replace one main bit-line inside a 72-line read set; the set holds 64 data lines and 8 parity lines. Row spares are main word-lines held in small redundant sectors.

Repair entries are written through a configuration port. This port is meant to be fed from the unerasable repair store during the power-up load. For every access, the block compares the sector, word-line and read-set address against the entries of the addressed group. It then registers the result together with the plain access address, so the substitution controls and the address reach the decoders in the same cycle.

A sector that uses row repair is tied to its redundant sector for every operation. Reads and programs are steered to the spare word-line. An erase of the repaired sector also selects the redundant sectors bound to it.

Top module: `rr_remap`

## Requirements
- R1: Reset clears the valid bit of every repair entry and drives every output low. An access after reset produces no hit until entries are written.
- R2: Every output changes one clock after the access is presented. `q_sector`, `q_row`, `q_colset` and `q_op` repeat the access. When `acc_valid` is low, `q_valid`, `col_hit`, `row_hit`, `col_steer`, `red_sec_mask` and `red_wl` are all zero.
- R3: For a read (`acc_op`=00), a program (01) or op 11, a valid column entry at (group = sector/8, read set = `acc_colset`) raises `col_hit`. It also sets exactly the bit of `col_steer` at the entry's line index, whatever the sector within the group and whatever the row.
- R4: An entry written with its valid bit low never produces a hit. A column entry whose line index is 72 or more never produces a hit.
- R5: For a non-erase access, a valid row entry in the addressed group raises `row_hit` when two things match: its sector field equals sector mod 8, and its main word-line equals `acc_row`/4. Slot s then sets bit s/4 of `red_sec_mask`, and `red_wl` = s mod 4.
- R6: When several row entries match the same access, the lowest slot number wins.
- R7: On an erase (`acc_op`=10), `col_hit` and `row_hit` stay low. Bit k of `red_sec_mask` is set when any valid entry in slots 4k to 4k+3 of the group names the erased sector.
- R8: A row hit and a column hit on the same access are both reported.
- R9: A configuration write replaces the addressed entry. Accesses presented in later cycles use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Repair entry write strobe |
| cfg_row | input | 1 | 1 writes a row entry, 0 a column entry |
| cfg_group | input | 3 | Vertical sector group of the entry |
| cfg_slot | input | 3 | Row slot (0..7) or, in the low 2 bits, the read set |
| cfg_valid | input | 1 | Valid bit of the entry |
| cfg_sec | input | 3 | Sector within the group (row entries) |
| cfg_addr | input | 7 | Main word-line (row) or failing line index (column) |
| acc_valid | input | 1 | Access present |
| acc_sector | input | 6 | Accessed sector |
| acc_row | input | 9 | Local word-line in the sector |
| acc_colset | input | 2 | Read set within the group |
| acc_op | input | 2 | 00 read, 01 program, 10 erase, 11 read |
| q_valid | output | 1 | Registered access valid |
| q_sector | output | 6 | Registered sector |
| q_row | output | 9 | Registered local word-line |
| q_colset | output | 2 | Registered read set |
| q_op | output | 2 | Registered operation |
| col_hit | output | 1 | Column spare replaces a line of the set |
| col_steer | output | 72 | One-hot: the line whose data comes from the spare |
| row_hit | output | 1 | Word-line is served by a spare word-line |
| red_sec_mask | output | 2 | Redundant sectors of the group taking part |
| red_wl | output | 2 | Spare main word-line within the redundant sector |

## Verification
On every cycle, the assertions check the shape of the outputs. `col_steer` is one-hot exactly when `col_hit` is set. A row hit selects exactly one redundant sector. An erase never raises either hit, and an idle cycle drives no substitution. A row hit also always comes with its sector binding. Whether the right line, the right slot and the right redundant sector are chosen can only be shown by the bench's scenarios. It sweeps every sector against a computed repair table, checks the erase binding of each sector, and runs directed cases for priority, overwrite and invalid entries.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } rr_op_e;
endpackage

// File: rtl/rr_col_table.sv
module rr_col_table #(
  parameter int GROUPS    = 8,
  parameter int COLSETS   = 4,
  parameter int SET_LINES = 72,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int CS_W   = $clog2(COLSETS),
  localparam int LINE_W = $clog2(SET_LINES),
  localparam int DEPTH  = GROUPS * COLSETS,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [GRP_W-1:0]  wr_group,
  input  logic [CS_W-1:0]   wr_set,
  input  logic              wr_valid,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [GRP_W-1:0]  rd_group,
  input  logic [CS_W-1:0]   rd_set,
  output logic              hit,
  output logic [LINE_W-1:0] line
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(SET_LINES - 1);

  logic [DEPTH-1:0]  vld;
  logic [LINE_W-1:0] line_mem [DEPTH];
  logic [IDX_W-1:0]  widx, ridx;

  assign widx = IDX_W'(wr_group * COLSETS + wr_set);
  assign ridx = IDX_W'(rd_group * COLSETS + rd_set);

  always_ff @(posedge clk) begin
    if (rst)     vld <= '0;
    else if (wr) vld[widx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr) line_mem[widx] <= wr_line;
  end

  always_comb begin
    line = line_mem[ridx];
    hit  = vld[ridx] && (line <= LAST_LINE);
  end
endmodule

// File: rtl/rr_row_table.sv
module rr_row_table #(
  parameter int GROUPS       = 8,
  parameter int SPARES       = 8,
  parameter int SECT_PER_GRP = 8,
  parameter int MWLS         = 128,
  parameter int RED_PER_GRP  = 2,
  localparam int GRP_W   = $clog2(GROUPS),
  localparam int SLOT_W  = $clog2(SPARES),
  localparam int OFF_W   = $clog2(SECT_PER_GRP),
  localparam int MWL_W   = $clog2(MWLS),
  localparam int PER_RED = SPARES / RED_PER_GRP,
  localparam int DEPTH   = GROUPS * SPARES,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic [GRP_W-1:0]       wr_group,
  input  logic [SLOT_W-1:0]      wr_slot,
  input  logic                   wr_valid,
  input  logic [OFF_W-1:0]       wr_off,
  input  logic [MWL_W-1:0]       wr_mwl,
  input  logic [GRP_W-1:0]       rd_group,
  input  logic [OFF_W-1:0]       rd_off,
  input  logic [MWL_W-1:0]       rd_mwl,
  output logic                   hit,
  output logic [SLOT_W-1:0]      slot,
  output logic [RED_PER_GRP-1:0] bound
);
  logic [DEPTH-1:0] vld;
  logic [OFF_W-1:0] off_mem [DEPTH];
  logic [MWL_W-1:0] mwl_mem [DEPTH];
  logic [IDX_W-1:0] widx;

  assign widx = IDX_W'(wr_group * SPARES + wr_slot);

  function automatic logic [IDX_W-1:0] entry_idx(input logic [GRP_W-1:0] g, input int s);
    return IDX_W'(g * SPARES + s);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     vld <= '0;
    else if (wr) vld[widx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      off_mem[widx] <= wr_off;
      mwl_mem[widx] <= wr_mwl;
    end
  end

  // descending scan: the last assignment, the lowest slot, wins
  always_comb begin
    hit   = 1'b0;
    slot  = '0;
    bound = '0;
    for (int s = SPARES - 1; s >= 0; s--) begin
      if (vld[entry_idx(rd_group, s)] && off_mem[entry_idx(rd_group, s)] == rd_off) begin
        bound[s / PER_RED] = 1'b1;
        if (mwl_mem[entry_idx(rd_group, s)] == rd_mwl) begin
          hit  = 1'b1;
          slot = SLOT_W'(s);
        end
      end
    end
  end

  p_hit_bound_r7: assert property (@(posedge clk) disable iff (rst)
    hit |-> bound[slot / PER_RED]);
endmodule

// File: rtl/rr_remap.sv
module rr_remap #(
  parameter int SECTORS      = 64,
  parameter int SECT_PER_GRP = 8,
  parameter int WL_PER_SECT  = 512,
  parameter int LWL_PER_MWL  = 4,
  parameter int COLSETS      = 4,
  parameter int SET_LINES    = 72,
  parameter int ROW_SPARES   = 8,
  parameter int RED_PER_GRP  = 2,
  localparam int GROUPS  = SECTORS / SECT_PER_GRP,
  localparam int MWLS    = WL_PER_SECT / LWL_PER_MWL,
  localparam int PER_RED = ROW_SPARES / RED_PER_GRP,
  localparam int SEC_W   = $clog2(SECTORS),
  localparam int ROW_W   = $clog2(WL_PER_SECT),
  localparam int CS_W    = $clog2(COLSETS),
  localparam int GRP_W   = $clog2(GROUPS),
  localparam int OFF_W   = $clog2(SECT_PER_GRP),
  localparam int MWL_W   = $clog2(MWLS),
  localparam int LINE_W  = $clog2(SET_LINES),
  localparam int SLOT_W  = $clog2(ROW_SPARES),
  localparam int RWL_W   = $clog2(PER_RED),
  localparam int ADDR_W  = (MWL_W > LINE_W) ? MWL_W : LINE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic                   cfg_row,
  input  logic [GRP_W-1:0]       cfg_group,
  input  logic [SLOT_W-1:0]      cfg_slot,
  input  logic                   cfg_valid,
  input  logic [OFF_W-1:0]       cfg_sec,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic                   acc_valid,
  input  logic [SEC_W-1:0]       acc_sector,
  input  logic [ROW_W-1:0]       acc_row,
  input  logic [CS_W-1:0]        acc_colset,
  input  logic [1:0]             acc_op,
  output logic                   q_valid,
  output logic [SEC_W-1:0]       q_sector,
  output logic [ROW_W-1:0]       q_row,
  output logic [CS_W-1:0]        q_colset,
  output logic [1:0]             q_op,
  output logic                   col_hit,
  output logic [SET_LINES-1:0]   col_steer,
  output logic                   row_hit,
  output logic [RED_PER_GRP-1:0] red_sec_mask,
  output logic [RWL_W-1:0]       red_wl
);
  import rr_pkg::*;

  logic [GRP_W-1:0]       grp;
  logic [OFF_W-1:0]       off;
  logic [MWL_W-1:0]       mwl;
  logic                   is_erase;
  logic                   c_hit, r_hit;
  logic [LINE_W-1:0]      c_line;
  logic [SLOT_W-1:0]      r_slot;
  logic [RED_PER_GRP-1:0] r_bound;

  logic                   col_hit_d, row_hit_d;
  logic [SET_LINES-1:0]   steer_d;
  logic [RED_PER_GRP-1:0] mask_d;
  logic [RWL_W-1:0]       wl_d;

  assign grp      = GRP_W'(acc_sector / SECT_PER_GRP);
  assign off      = OFF_W'(acc_sector % SECT_PER_GRP);
  assign mwl      = MWL_W'(acc_row / LWL_PER_MWL);
  assign is_erase = (acc_op == OP_ERASE);

  rr_col_table #(
    .GROUPS(GROUPS), .COLSETS(COLSETS), .SET_LINES(SET_LINES)
  ) u_col (
    .clk(clk), .rst(rst),
    .wr(cfg_wr && !cfg_row), .wr_group(cfg_group), .wr_set(cfg_slot[CS_W-1:0]),
    .wr_valid(cfg_valid), .wr_line(cfg_addr[LINE_W-1:0]),
    .rd_group(grp), .rd_set(acc_colset),
    .hit(c_hit), .line(c_line)
  );

  rr_row_table #(
    .GROUPS(GROUPS), .SPARES(ROW_SPARES), .SECT_PER_GRP(SECT_PER_GRP),
    .MWLS(MWLS), .RED_PER_GRP(RED_PER_GRP)
  ) u_row (
    .clk(clk), .rst(rst),
    .wr(cfg_wr && cfg_row), .wr_group(cfg_group), .wr_slot(cfg_slot),
    .wr_valid(cfg_valid), .wr_off(cfg_sec), .wr_mwl(cfg_addr[MWL_W-1:0]),
    .rd_group(grp), .rd_off(off), .rd_mwl(mwl),
    .hit(r_hit), .slot(r_slot), .bound(r_bound)
  );

  assign col_hit_d = acc_valid && !is_erase && c_hit;
  assign row_hit_d = acc_valid && !is_erase && r_hit;

  for (genvar i = 0; i < SET_LINES; i++) begin : g_steer
    assign steer_d[i] = col_hit_d && (c_line == LINE_W'(i));
  end

  always_comb begin
    mask_d = '0;
    wl_d   = '0;
    if (row_hit_d) begin
      mask_d[r_slot / PER_RED] = 1'b1;
      wl_d = RWL_W'(r_slot % PER_RED);
    end else if (acc_valid && is_erase) begin
      mask_d = r_bound;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid      <= 1'b0;
      q_sector     <= '0;
      q_row        <= '0;
      q_colset     <= '0;
      q_op         <= '0;
      col_hit      <= 1'b0;
      col_steer    <= '0;
      row_hit      <= 1'b0;
      red_sec_mask <= '0;
      red_wl       <= '0;
    end else begin
      q_valid      <= acc_valid;
      q_sector     <= acc_sector;
      q_row        <= acc_row;
      q_colset     <= acc_colset;
      q_op         <= acc_op;
      col_hit      <= col_hit_d;
      col_steer    <= steer_d;
      row_hit      <= row_hit_d;
      red_sec_mask <= mask_d;
      red_wl       <= wl_d;
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !q_valid |-> (!col_hit && !row_hit && red_sec_mask == '0));
  p_steer_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    col_hit |-> $onehot(col_steer));
  p_steer_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !col_hit |-> (col_steer == '0));
  p_row_one_sector_r5: assert property (@(posedge clk) disable iff (rst)
    row_hit |-> $onehot(red_sec_mask));
  p_erase_no_hit_r7: assert property (@(posedge clk) disable iff (rst)
    (q_valid && q_op == OP_ERASE) |-> (!col_hit && !row_hit));
endmodule

// File: tb/test_rr_remap.sv
module test_rr_remap;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_row = 0, cfg_valid = 0;
  logic [2:0] cfg_group = 0, cfg_slot = 0, cfg_sec = 0;
  logic [6:0] cfg_addr = 0;
  logic acc_valid = 0;
  logic [5:0] acc_sector = 0;
  logic [8:0] acc_row = 0;
  logic [1:0] acc_colset = 0, acc_op = 0;
  logic q_valid, col_hit, row_hit;
  logic [5:0] q_sector;
  logic [8:0] q_row;
  logic [1:0] q_colset, q_op, red_sec_mask, red_wl;
  logic [71:0] col_steer;

  int checks = 0, failures = 0;
  bit done = 0;

  bit cv [8][4];
  int cl [8][4];
  bit rv [8][8];
  int rs [8][8];
  int rm [8][8];

  always #2.5 clk = ~clk;

  rr_remap i_rr_remap (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_row(cfg_row), .cfg_group(cfg_group),
    .cfg_slot(cfg_slot), .cfg_valid(cfg_valid), .cfg_sec(cfg_sec), .cfg_addr(cfg_addr),
    .acc_valid(acc_valid), .acc_sector(acc_sector), .acc_row(acc_row),
    .acc_colset(acc_colset), .acc_op(acc_op), .q_valid(q_valid), .q_sector(q_sector),
    .q_row(q_row), .q_colset(q_colset), .q_op(q_op), .col_hit(col_hit),
    .col_steer(col_steer), .row_hit(row_hit), .red_sec_mask(red_sec_mask), .red_wl(red_wl)
  );

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    acc_valid = 0;
    cfg_wr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int g = 0; g < 8; g++) begin
      for (int s = 0; s < 4; s++) cv[g][s] = 0;
      for (int s = 0; s < 8; s++) rv[g][s] = 0;
    end
  endtask

  task automatic cfg_col(input int g, input int s, input bit v, input int line);
    cfg_wr = 1; cfg_row = 0; cfg_group = 3'(g); cfg_slot = 3'(s);
    cfg_valid = v; cfg_sec = 0; cfg_addr = 7'(line);
    cv[g][s] = v; cl[g][s] = line;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic cfg_rw(input int g, input int s, input bit v, input int sec, input int mwl);
    cfg_wr = 1; cfg_row = 1; cfg_group = 3'(g); cfg_slot = 3'(s);
    cfg_valid = v; cfg_sec = 3'(sec); cfg_addr = 7'(mwl);
    rv[g][s] = v; rs[g][s] = sec; rm[g][s] = mwl;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  // one access: drive at a falling edge, compare at the next falling edge
  task automatic access(input int sec, input int row, input int cs, input int op,
                        input bit v, input string req);
    int g, off, mwl, first;
    bit er, ech, erh;
    logic [71:0] esteer;
    logic [1:0] emask, ewl;
    string tc, tr, tp;
    g = sec / 8; off = sec % 8; mwl = row / 4; er = (op == 2);
    ech = v && !er && cv[g][cs] && cl[g][cs] < 72;
    esteer = '0;
    if (ech) esteer[cl[g][cs]] = 1'b1;
    first = -1;
    emask = 0;
    ewl = 0;
    for (int s = 7; s >= 0; s--)
      if (rv[g][s] && rs[g][s] == off) begin
        if (er) emask[s / 4] = 1'b1;
        else if (rm[g][s] == mwl) first = s;
      end
    if (!v) emask = 0;
    erh = v && !er && first >= 0;
    if (erh) begin
      emask = 2'b00;
      emask[first / 4] = 1'b1;
      ewl = 2'(first % 4);
    end
    tc = (req != "") ? {req, " column"} : "R3 column";
    tr = (req != "") ? {req, " row"} : (er ? "R7 erase binding" : "R5 row");
    tp = (req != "") ? {req, " address"} : "R2 address";
    acc_valid = v; acc_sector = 6'(sec); acc_row = 9'(row);
    acc_colset = 2'(cs); acc_op = 2'(op);
    @(negedge clk);
    check(tc, {55'd0, col_hit, col_steer}, {55'd0, ech, esteer});
    check(tr, {123'd0, row_hit, red_sec_mask, red_wl}, {123'd0, erh, emask, ewl});
    if (v) check(tp, {108'd0, q_valid, q_sector, q_row, q_colset, q_op},
                     {108'd0, 1'b1, 6'(sec), 9'(row), 2'(cs), 2'(op)});
    else   check(tp, {127'd0, q_valid}, 128'd0);
  endtask

  initial begin
    do_reset();
    // R1: reset state and an empty table
    check("R1 reset outputs", {108'd0, q_valid, col_hit, row_hit, red_sec_mask, red_wl, col_steer != 0},
          128'd0);
    access(9, 100, 2, 0, 1, "R1");
    access(9, 100, 2, 2, 1, "R1");

    // R4: invalid entry and out-of-range line
    cfg_col(0, 0, 0, 5);
    access(0, 0, 0, 0, 1, "R4");
    cfg_col(0, 1, 1, 75);
    access(3, 0, 1, 0, 1, "R4");
    cfg_rw(0, 3, 0, 4, 2);
    access(4, 8, 0, 0, 1, "R4");

    // R3: column hit anywhere in the group, top line
    cfg_col(0, 1, 1, 71);
    access(3, 200, 1, 1, 1, "R3");
    access(7, 5, 1, 3, 1, "R3");

    // R6: two slots match, lowest wins
    cfg_rw(0, 5, 1, 2, 9);
    cfg_rw(0, 1, 1, 2, 9);
    access(2, 36, 0, 0, 1, "R6");
    access(2, 39, 0, 1, 1, "R6");

    // R7: erase binds both redundant sectors; no hits on erase
    access(2, 36, 1, 2, 1, "R7");
    access(3, 36, 1, 2, 1, "R7");

    // R8: both substitutions on one access
    access(2, 37, 1, 0, 1, "R8");

    // R2: idle access with matching address
    access(2, 37, 1, 0, 0, "R2");

    // R9: overwrite slot 1
    cfg_rw(0, 1, 1, 2, 10);
    access(2, 37, 0, 0, 1, "R9");
    access(2, 41, 0, 0, 1, "R9");

    // computed table over every group, then sweep all sectors
    do_reset();
    for (int g = 0; g < 8; g++) begin
      for (int s = 0; s < 4; s++) cfg_col(g, s, ((g + s) % 3) != 0, (g * 13 + s * 29) % 80);
      for (int s = 0; s < 8; s++) begin
        if (s >= 4 && g % 2 == 0) cfg_rw(g, s, 1, rs[g][s - 4], rm[g][s - 4]);
        else cfg_rw(g, s, ((g + s) % 4) != 3, (g * 3 + s) % 8, (g * 7 + s * 5) % 16);
      end
    end
    for (int sec = 0; sec < 64; sec++)
      for (int m = 0; m < 20; m++)
        access(sec, m * 4 + (sec % 4), (sec + m) % 4, (m % 4 == 2) ? 3 : (m % 2), 1, "");
    for (int sec = 0; sec < 64; sec++)
      access(sec, (sec * 7) % 512, sec % 4, 2, 1, "");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule